// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This peripheral owns a 16-bit counter that advances on every clock and can be neither stopped nor reloaded. Two functions share that count. The capture path watches an external input line and copies the count into a capture register when the selected edge arrives. The compare path checks the count against a programmed value on every cycle. When they are equal, the compare path raises a flag and drives an output pin to a level that software chose earlier.

Software reaches the block through a byte-wide register port with a one-cycle read latency. Reading the upper counter byte freezes the lower byte, so a two-access read returns a consistent 16-bit value. A write to the upper compare byte is staged, and the following write to the lower byte commits both bytes at once. Event flags stay set until software writes a 1 to them.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the count is 0x0000. It increases by one on every clock and wraps from 0xFFFF to 0x0000. Writes to the counter addresses (0 and 1) have no effect on it.
- R2: The input line passes through a two-flop synchronizer. When the edge chosen by CTRL bit 0 (1 = rising, 0 = falling) is seen, the capture register (high byte at address 2, low byte at address 3) loads the count. If the input changes just before clock edge k, the value captured is the count held before edge k+2. An edge of the other polarity leaves the register unchanged.
- R3: Each capture sets the capture flag, which is bit 1 of FLAGS (address 7).
- R4: At the clock edge where the count equals the compare value, the compare flag is set. The compare flag is bit 0 of FLAGS.
- R5: At that same edge, the output pin takes the value of CTRL bit 1 (CTRL is at address 6).
- R6: When no match occurs, the output pin keeps its level, even if CTRL bit 1 changes.
- R7: Writing FLAGS clears each flag whose data bit is 1; a 0 bit has no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: Reading address 0 returns the upper count byte and freezes the lower byte. The next read of address 1 returns the frozen byte and releases it. A read of address 1 with no freeze pending returns the live lower byte.
- R9: A write to address 4 stages the upper compare byte. A write to address 5 commits the staged byte together with the new lower byte. Reads of addresses 4 and 5 return the committed value. The compare value resets to 0xFFFF.
- R10: Read data appears on the cycle after the read strobe. After reset, read data, CTRL, both flags, the capture register and the output pin are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_out | output | 1 | Compare output pin |

## Verification
The hardest case is a capture event and a compare match landing on the same clock edge while a software flag-clear write lands on that edge too. The bench keeps its own model of the count. It raises the input line two cycles before the count reaches the compare value, and it issues the clear write on the cycle of the match. It then expects both flags to stay set, the capture register to hold the compare value, and the pin to take the programmed level. Reads are scored against the modelled count, including a frozen low-byte read that straddles the wrap.

// File: rtl/capcmp_pkg.sv
// Package: register addresses and control bit positions shared by the timer.
// Assumes a byte-wide register port with eight locations.
package capcmp_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_HI = 3'd0,
        RA_CNT_LO = 3'd1,
        RA_CAP_HI = 3'd2,
        RA_CAP_LO = 3'd3,
        RA_CMP_HI = 3'd4,
        RA_CMP_LO = 3'd5,
        RA_CTRL   = 3'd6,
        RA_FLAGS  = 3'd7
    } reg_addr_e;

    localparam int CTRL_RISE_BIT = 0;
    localparam int CTRL_LVL_BIT  = 1;
    localparam int FLAG_CMP_BIT  = 0;
    localparam int FLAG_CAP_BIT  = 1;
endpackage

// File: rtl/capcmp_edge.sv
// Synchronizes an asynchronous input and reports one chosen edge.
// Assumes STAGES >= 2; evt lasts one cycle for each qualifying transition.
module capcmp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              s_now;

    assign s_now = sync_q[STAGES-1];

    // Shift chain into the clock domain, plus one delayed copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= s_now;
        end
    end

    // Pick the polarity that software selected.
    always_comb begin
        if (rise_sel) evt = s_now & ~prev_q;
        else          evt = ~s_now & prev_q;
    end
endmodule

// File: rtl/capcmp_count.sv
// Free-running up counter; no load or stop input by design.
// Assumes natural wrap at 2**W.
module capcmp_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Advance by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/capcmp_match.sv
// Equality detector and output pin driver for the compare path.
// Assumes the level input is stable software state; the pin moves only on a hit.
module capcmp_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         lvl,
    output logic         hit,
    output logic         pin
);
    assign hit = (cnt == cmp);

    // Load the programmed level on a hit, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   pin <= 1'b0;
        else if (hit) pin <= lvl;
    end
endmodule

// File: rtl/capcmp_timer.sv
// Top of the capture/compare timer: register port, flags, capture and compare registers.
// Assumes a counter exactly two bus bytes wide; single-cycle strobes, registered read data.
module capcmp_timer #(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [capcmp_pkg::ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]            wdata,
    output logic [BUS_W-1:0]            rdata,
    input  logic                        cap_in,
    output logic                        cmp_out
);
    import capcmp_pkg::*;

    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cmp_q;
    logic [BUS_W-1:0] stage_hi_q;
    logic [BUS_W-1:0] lo_hold_q;
    logic             hold_vld_q;
    logic [1:0]       ctrl_q;
    logic             cmp_flag;
    logic             cap_flag;
    logic             cap_evt;
    logic             hit;
    logic             ctrl_lvl;
    logic             clr_cmp;
    logic             clr_cap;
    logic             flags_wr;

    assign ctrl_lvl = ctrl_q[CTRL_LVL_BIT];
    assign flags_wr = wr_en && (addr == RA_FLAGS);
    assign clr_cmp  = flags_wr && wdata[FLAG_CMP_BIT];
    assign clr_cap  = flags_wr && wdata[FLAG_CAP_BIT];

    capcmp_count #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_q)
    );

    capcmp_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cap_in),
        .rise_sel (ctrl_q[CTRL_RISE_BIT]),
        .evt      (cap_evt)
    );

    capcmp_match #(.W(CNT_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_q),
        .cmp   (cmp_q),
        .lvl   (ctrl_lvl),
        .hit   (hit),
        .pin   (cmp_out)
    );

    // Latch the count into the capture register on a qualifying edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt_q;
    end

    // Software-writable state: control bits and the staged compare register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            stage_hi_q <= '0;
            cmp_q      <= '1;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL:   ctrl_q     <= wdata[1:0];
                RA_CMP_HI: stage_hi_q <= wdata;
                RA_CMP_LO: cmp_q      <= {stage_hi_q, wdata};
                default:   ;
            endcase
        end
    end

    // Sticky event flags; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            if (hit)          cmp_flag <= 1'b1;
            else if (clr_cmp) cmp_flag <= 1'b0;
            if (cap_evt)      cap_flag <= 1'b1;
            else if (clr_cap) cap_flag <= 1'b0;
        end
    end

    // Registered read port with the low-byte freeze for coherent count reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            lo_hold_q  <= '0;
            hold_vld_q <= 1'b0;
        end else if (rd_en) begin
            case (addr)
                RA_CNT_HI: begin
                    rdata      <= cnt_q[CNT_W-1:BUS_W];
                    lo_hold_q  <= cnt_q[BUS_W-1:0];
                    hold_vld_q <= 1'b1;
                end
                RA_CNT_LO: begin
                    rdata      <= hold_vld_q ? lo_hold_q : cnt_q[BUS_W-1:0];
                    hold_vld_q <= 1'b0;
                end
                RA_CAP_HI: rdata <= cap_q[CNT_W-1:BUS_W];
                RA_CAP_LO: rdata <= cap_q[BUS_W-1:0];
                RA_CMP_HI: rdata <= cmp_q[CNT_W-1:BUS_W];
                RA_CMP_LO: rdata <= cmp_q[BUS_W-1:0];
                RA_CTRL:   rdata <= BUS_W'(ctrl_q);
                default:   rdata <= BUS_W'({cap_flag, cmp_flag});
            endcase
        end
    end
endmodule

// File: rtl/capcmp_timer_chk.sv
// Checker for the capture/compare timer, attached to every instance by bind.
// Assumes the internal names of capcmp_timer listed in the bind below.
module capcmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] cap,
    input logic             cap_evt,
    input logic             lvl,
    input logic             pin,
    input logic             cmp_flag,
    input logic             cap_flag,
    input logic             clr_cmp
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> cap == $past(cnt)); // R2
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !cap_evt |=> $stable(cap)); // R2
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> cap_flag); // R3
    AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (cnt == cmp) |=> cmp_flag); // R4
    AST_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (cnt == cmp) |=> pin == $past(lvl)); // R5
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt != cmp) |=> $stable(pin)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (cmp_flag && !clr_cmp) |=> cmp_flag); // R7
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .cmp      (cmp_q),
    .cap      (cap_q),
    .cap_evt  (cap_evt),
    .lvl      (ctrl_lvl),
    .pin      (cmp_out),
    .cmp_flag (cmp_flag),
    .cap_flag (cap_flag),
    .clr_cmp  (clr_cmp)
);

// File: tb/capcmp_timer_bench.sv
// Scoreboard bench: read tasks queue expected bytes, a negedge monitor scores them.
module capcmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cap_in = 1'b0;
    logic       cmp_out;

    int total = 0;
    int bad = 0;
    logic [15:0] mcnt = '0;
    logic [7:0]  hold_m = '0;
    bit          hold_v = 1'b0;
    logic        rd_seen = 1'b0;
    bit          timed_out = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    capcmp_timer u_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    // Count model: one per clock, zero under reset.
    always @(posedge clk) begin
        if (!rst_n) mcnt <= '0;
        else        mcnt <= mcnt + 16'd1;
        rd_seen <= rd_en;
    end

    function automatic void chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endfunction

    // Monitor: score read data the cycle after each strobe.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) chk(1'b0, "R10 unexpected read", rdata, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                chk(rdata == e.val, e.tag, rdata, e.val);
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] exp_in, input string tag);
        exp_t e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        if (a == 3'd0) begin
            e.val = mcnt[15:8]; hold_m = mcnt[7:0]; hold_v = 1'b1;
        end else if (a == 3'd1) begin
            e.val = hold_v ? hold_m : mcnt[7:0]; hold_v = 1'b0;
        end else e.val = exp_in;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        while (mcnt != v) @(negedge clk);
    endtask

    task automatic run_test();
        logic [15:0] v;
        logic [15:0] m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(cmp_out == 1'b0, "R10 pin after reset", cmp_out, 0);
        chk(rdata == 8'h00, "R10 rdata after reset", rdata, 0);
        rd(3'd7, 8'h00, "R10 flags reset");
        rd(3'd6, 8'h00, "R10 ctrl reset");
        rd(3'd2, 8'h00, "R10 capture reset");
        rd(3'd4, 8'hFF, "R9 compare reset high");
        // R8 coherent read: low byte frozen across a long gap
        rd(3'd0, 8'h00, "R8 count high");
        repeat (300) @(negedge clk);
        rd(3'd1, 8'h00, "R8 frozen low");
        rd(3'd1, 8'h00, "R8 live low");
        // R1 writes to counter ignored
        wr(3'd0, 8'h55); wr(3'd1, 8'hAA);
        rd(3'd0, 8'h00, "R1 count high after write");
        rd(3'd1, 8'h00, "R1 count low after write");
        // R9/R5/R4 compare with level 1
        wr(3'd6, 8'h02);
        v = mcnt + 16'd40;
        wr(3'd4, v[15:8]);
        rd(3'd4, 8'hFF, "R9 staged high not visible");
        wr(3'd5, v[7:0]);
        rd(3'd4, v[15:8], "R9 committed high");
        rd(3'd5, v[7:0], "R9 committed low");
        wait_cnt(v);
        chk(cmp_out == 1'b0, "R6 pin before match", cmp_out, 0);
        @(negedge clk);
        chk(cmp_out == 1'b1, "R5 pin at match", cmp_out, 1);
        rd(3'd7, 8'h01, "R4 compare flag set");
        wr(3'd7, 8'h00);
        rd(3'd7, 8'h01, "R7 zero write keeps flag");
        wr(3'd7, 8'h01);
        rd(3'd7, 8'h00, "R7 one write clears flag");
        // R6 hold while level changes, then R5 new match drives 0
        wr(3'd6, 8'h00);
        repeat (100) @(negedge clk);
        chk(cmp_out == 1'b1, "R6 pin holds", cmp_out, 1);
        v = mcnt + 16'd30;
        wr(3'd4, v[15:8]); wr(3'd5, v[7:0]);
        wait_cnt(v);
        @(negedge clk);
        chk(cmp_out == 1'b0, "R5 pin second match", cmp_out, 0);
        wr(3'd7, 8'h03);
        // R2/R3 rising capture
        wr(3'd6, 8'h01);
        @(negedge clk);
        cap_in = 1'b1; m0 = mcnt + 16'd2;
        repeat (4) @(negedge clk);
        rd(3'd2, m0[15:8], "R2 rising capture high");
        rd(3'd3, m0[7:0], "R2 rising capture low");
        rd(3'd7, 8'h02, "R3 capture flag");
        wr(3'd7, 8'h02);
        @(negedge clk);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd7, 8'h00, "R2 wrong edge no flag");
        rd(3'd3, m0[7:0], "R2 wrong edge no capture");
        // R2 falling capture
        wr(3'd6, 8'h00);
        @(negedge clk);
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        cap_in = 1'b0; m0 = mcnt + 16'd2;
        repeat (4) @(negedge clk);
        rd(3'd2, m0[15:8], "R2 falling capture high");
        rd(3'd3, m0[7:0], "R2 falling capture low");
        rd(3'd7, 8'h02, "R3 falling capture flag");
        // R7 same edge: match, capture and clear write
        wr(3'd7, 8'h03);
        wr(3'd6, 8'h03);
        v = mcnt + 16'd60;
        wr(3'd4, v[15:8]); wr(3'd5, v[7:0]);
        wait_cnt(v - 16'd2);
        cap_in = 1'b1;
        wait_cnt(v);
        wr_en = 1'b1; addr = 3'd7; wdata = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd7, 8'h03, "R7 set wins over clear");
        rd(3'd2, v[15:8], "R2 capture on match edge high");
        rd(3'd3, v[7:0], "R2 capture on match edge low");
        chk(cmp_out == 1'b1, "R5 pin on shared edge", cmp_out, 1);
        // R1 wrap and R8 freeze across it
        wr(3'd6, 8'h01);
        wr(3'd4, 8'h00); wr(3'd5, 8'h01);
        wait_cnt(16'hFFFD);
        rd(3'd0, 8'h00, "R8 high before wrap");
        rd(3'd1, 8'h00, "R8 frozen low across wrap");
        wait_cnt(16'h0001);
        chk(cmp_out == 1'b1, "R6 pin before wrapped match", cmp_out, 1);
        @(negedge clk);
        chk(cmp_out == 1'b0, "R1 wrap reaches compare 1", cmp_out, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule